// File: doc/BRIEF.md
# In-order pipeline stall controller

This block is a cycle-accurate timing model of a four-stage in-order instruction pipeline with fetch, decode, execute and writeback stages. It does not decode instructions. Each instruction arrives as an abstract descriptor through a valid/ready handshake. The descriptor holds the number of cycles the instruction spends in decode and in execute, a flag marking it as a load, one destination register tag, two source register tags and a sequence tag. The block moves these descriptors through the stages. It reports which stages are occupied, and it raises a retire strobe carrying the sequence tag when an instruction completes.

Each stage keeps its own occupancy countdown. A long decode hold, such as a multi-register stack pop, can therefore run while an older instruction sits in a long execute hold, such as a load from slow external memory. The two waits overlap instead of adding up. A stage that is waiting holds the stages behind it, and the stages ahead of it receive bubbles. A small scoreboard keeps an instruction in decode while one of its source tags names the destination of a load that is still in execute.

The block also has a free-running cycle counter. A testbench uses it to compare the total run time of a reordered instruction stream with that of the same stream in its original order.

Top module: `pipe_stall_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, all four stages become empty, `retire_valid` is 0, `cycle_count` is 0 and `in_ready` is 1.
- R2: `in_ready` is 1 exactly when the fetch stage is empty or its instruction moves into decode on the next edge. A descriptor is taken only on an edge where `in_valid` and `in_ready` are both 1. While decode keeps its instruction, the fetch instruction stays in place.
- R3: An instruction stays in decode for `in_dec_cyc` cycles, where a value of 0 counts as 1. It stays longer only when execute cannot take it or a load dependency holds it.
- R4: An instruction stays in execute for `in_exe_cyc` cycles, where a value of 0 counts as 1. With nothing else in flight, an instruction taken at edge t retires in the cycle after edge t + 1 + D + E, where D and E are the counts adjusted so that 0 counts as 1.
- R5: A younger instruction counts down its decode cycles while an older instruction is in execute. It moves into execute on the same edge on which execute empties. For a 1-cycle-decode instruction with execute count E1 followed by one with decode count D2 and execute count 1, the second retires 3 + max(D2, E1) cycles after the first is taken.
- R6: Writeback holds each instruction for exactly one cycle. In every cycle in which execute is still counting down, writeback receives a bubble.
- R7: An instruction with `in_is_load` = 1 marks its destination tag busy from the edge on which it enters execute until the edge on which it leaves execute. A younger instruction whose `in_src_a` or `in_src_b` equals a busy tag leaves decode no earlier than the edge after the load leaves execute. Destinations of non-load instructions never hold anything.
- R8: `retire_valid` is 1 for exactly one cycle per instruction, in program order, and `retire_seq` then shows that instruction's `in_seq`.
- R9: After reset, `cycle_count` increases by one on every clock edge.
- R10: For the example stream of two 4-cycle-decode pops, four moves, two 8-cycle loads, an add that uses both loads and a store, placing each pop directly after a load finishes the stream in fewer cycles than the original order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Descriptor offered |
| in_ready | output | 1 | Fetch stage can take the descriptor on this edge |
| in_seq | input | SEQ_W | Sequence tag reported at retirement |
| in_dec_cyc | input | CNT_W | Cycles in decode (0 counts as 1) |
| in_exe_cyc | input | CNT_W | Cycles in execute (0 counts as 1) |
| in_is_load | input | 1 | Instruction is a load; its destination is tracked for dependencies |
| in_dst | input | TAG_W | Destination register tag |
| in_src_a | input | TAG_W | First source register tag |
| in_src_b | input | TAG_W | Second source register tag |
| stage_full | output | 4 | Stage occupied: bit 0 fetch, bit 1 decode, bit 2 execute, bit 3 writeback |
| retire_valid | output | 1 | An instruction completes writeback this cycle |
| retire_seq | output | SEQ_W | Sequence tag of the retiring instruction |
| cycle_count | output | CYC_W | Free-running cycle counter, cleared by reset |

## Verification
The hardest situation to reach is one where three kinds of wait are active at once: a younger instruction counting down in decode, a long load holding execute, and a dependency on that load that becomes free on the very edge on which execute empties. The stimulus reaches it with sweeps. One sweep covers every pairing of a 0..15 execute count with a 0..15 decode count behind it. Another places a load of 0..8 execute cycles ahead of its consumer with zero to three independent fillers between them, once with the load flag set and once with it clear. The bench computes the entry and exit edge of every instruction in every stage arithmetically. It compares stage occupancy, `in_ready` and the retire strobe against these edges in every cycle.

// File: rtl/pipe_stall_pkg.sv
// pipe_stall_pkg
// Shared stage indices for the in-order pipeline stall controller.
// Assumes stages are numbered in program-flow order, with writeback last.
package pipe_stall_pkg;
    localparam int NUM_ST = 4;
    localparam int ST_F   = 0;
    localparam int ST_D   = 1;
    localparam int ST_E   = 2;
    localparam int ST_W   = 3;
endpackage

// File: rtl/pl_stage.sv
// pl_stage
// One pipeline slot that holds a payload for a programmable number of cycles.
// When it takes a new payload it loads a countdown (0 counts as 1). The payload
// leaves once the countdown reaches 1 and the downstream permits it.
// Assumes take is raised only while accept is high.
module pl_stage #(
    parameter int PW    = 16,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [PW-1:0]    pay_in,
    input  logic [CNT_W-1:0] cnt_in,
    input  logic             release_ok,
    output logic             valid,
    output logic [PW-1:0]    pay,
    output logic             done,
    output logic             leaving,
    output logic             accept
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;

    // Handshake with neighbours: finished, may leave, and slot available.
    assign done    = valid && (cnt == ONE);
    assign leaving = done && release_ok;
    assign accept  = !valid || leaving;

    // Occupancy and countdown register for this slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            cnt   <= '0;
            pay   <= '0;
        end else if (accept) begin
            valid <= take;
            if (take) begin
                pay <= pay_in;
                cnt <= (cnt_in == '0) ? ONE : cnt_in;
            end else begin
                cnt <= '0;
            end
        end else if (cnt > ONE) begin
            cnt <= cnt - ONE;
        end
    end

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && cnt > ONE) |=> (valid && cnt == $past(cnt) - ONE));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !leaving) |=> (valid && $stable(pay)));

    // R2
    take_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> accept);
endmodule

// File: rtl/pl_scoreboard.sv
// pl_scoreboard
// Busy bit per register tag for loads that are in execute.
// The bit is set when a load enters execute and cleared when it leaves.
// Set wins when both happen to the same tag on the same edge.
// Assumes tags are TAG_W wide, so there are 2**TAG_W bits.
module pl_scoreboard #(
    parameter int TAG_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [TAG_W-1:0] set_tag,
    input  logic             clr_en,
    input  logic [TAG_W-1:0] clr_tag,
    input  logic [TAG_W-1:0] chk_a,
    input  logic [TAG_W-1:0] chk_b,
    output logic             hazard
);
    localparam int NTAG = 1 << TAG_W;

    logic [NTAG-1:0] busy;

    for (genvar t = 0; t < NTAG; t++) begin : g_bit
        // Keep track of one tag's pending-load state.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy[t] <= 1'b0;
            end else if (set_en && set_tag == TAG_W'(t)) begin
                busy[t] <= 1'b1;
            end else if (clr_en && clr_tag == TAG_W'(t)) begin
                busy[t] <= 1'b0;
            end
        end
    end

    // Either source naming a pending load blocks the instruction.
    assign hazard = busy[chk_a] || busy[chk_b];

    // R7
    busy_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !(set_en && set_tag == clr_tag)) |=> !busy[$past(clr_tag)]);

    // R7
    busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> busy[$past(set_tag)]);
endmodule

// File: rtl/pl_cycle_ctr.sv
// pl_cycle_ctr
// Free-running cycle counter that is cleared by the synchronous reset.
// Assumes wrap-around at 2**W is acceptable.
module pl_cycle_ctr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] count
);
    // Advance by one every edge outside reset.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count + W'(1);
    end

    // R9
    cyc_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> count == $past(count) + W'(1));
endmodule

// File: rtl/pipe_stall_ctrl.sv
// pipe_stall_ctrl
// Four-stage in-order pipeline timing model: fetch, decode, execute, writeback.
// Decode and execute hold an instruction for the counts it carries. The other
// stages hold for one cycle. Each stage counts down on its own, so a decode hold
// and an older execute hold overlap. A stage that cannot move on holds the stages
// upstream, and the stages downstream receive bubbles. Decode also waits on the
// load scoreboard. Assumes the descriptor fields are stable while in_valid is high.
module pipe_stall_ctrl
    import pipe_stall_pkg::*;
#(
    parameter int TAG_W = 3,
    parameter int SEQ_W = 8,
    parameter int CNT_W = 4,
    parameter int CYC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [SEQ_W-1:0] in_seq,
    input  logic [CNT_W-1:0] in_dec_cyc,
    input  logic [CNT_W-1:0] in_exe_cyc,
    input  logic             in_is_load,
    input  logic [TAG_W-1:0] in_dst,
    input  logic [TAG_W-1:0] in_src_a,
    input  logic [TAG_W-1:0] in_src_b,
    output logic [3:0]       stage_full,
    output logic             retire_valid,
    output logic [SEQ_W-1:0] retire_seq,
    output logic [CYC_W-1:0] cycle_count
);
    // Payload layout, low to high: exe count, dec count, src b, src a, dst, load, seq.
    localparam int EXE_LO = 0;
    localparam int DEC_LO = EXE_LO + CNT_W;
    localparam int SB_LO  = DEC_LO + CNT_W;
    localparam int SA_LO  = SB_LO + TAG_W;
    localparam int DST_LO = SA_LO + TAG_W;
    localparam int LD_BIT = DST_LO + TAG_W;
    localparam int SEQ_LO = LD_BIT + 1;
    localparam int PW     = SEQ_LO + SEQ_W;

    logic [PW-1:0]     in_pay;
    logic [PW-1:0]     st_pay [NUM_ST];
    logic [NUM_ST-1:0] st_valid;
    logic [NUM_ST-1:0] st_done;
    logic [NUM_ST-1:0] st_leave;
    logic [NUM_ST-1:0] st_accept;
    logic [NUM_ST-1:0] st_rel;
    logic              hazard;

    // Pack the incoming descriptor into a single payload word.
    assign in_pay = {in_seq, in_is_load, in_dst, in_src_a, in_src_b, in_dec_cyc, in_exe_cyc};

    // Named fields of the decode and execute slots.
    logic             d_is_load, e_is_load;
    logic [TAG_W-1:0] d_dst, d_src_a, d_src_b, e_dst;
    logic [SEQ_W-1:0] d_seq, e_seq;

    assign d_is_load = st_pay[ST_D][LD_BIT];
    assign d_dst     = st_pay[ST_D][DST_LO +: TAG_W];
    assign d_src_a   = st_pay[ST_D][SA_LO +: TAG_W];
    assign d_src_b   = st_pay[ST_D][SB_LO +: TAG_W];
    assign d_seq     = st_pay[ST_D][SEQ_LO +: SEQ_W];
    assign e_is_load = st_pay[ST_E][LD_BIT];
    assign e_dst     = st_pay[ST_E][DST_LO +: TAG_W];
    assign e_seq     = st_pay[ST_E][SEQ_LO +: SEQ_W];

    for (genvar s = 0; s < NUM_ST; s++) begin : g_st
        logic             take_s;
        logic [PW-1:0]    pin_s;
        logic [CNT_W-1:0] cnt_s;

        // Upstream source of this slot: the input port or the previous stage.
        if (s == ST_F) begin : g_src_in
            assign take_s = in_valid && st_accept[s];
            assign pin_s  = in_pay;
        end else begin : g_src_prev
            assign take_s = st_leave[s-1];
            assign pin_s  = st_pay[s-1];
        end

        // Residence count: decode and execute use the descriptor, the rest use one.
        if (s == ST_D) begin : g_cnt_dec
            assign cnt_s = pin_s[DEC_LO +: CNT_W];
        end else if (s == ST_E) begin : g_cnt_exe
            assign cnt_s = pin_s[EXE_LO +: CNT_W];
        end else begin : g_cnt_one
            assign cnt_s = CNT_W'(1);
        end

        // Permission to leave: writeback always drains, decode also checks loads.
        if (s == NUM_ST - 1) begin : g_rel_last
            assign st_rel[s] = 1'b1;
        end else if (s == ST_D) begin : g_rel_dec
            assign st_rel[s] = st_accept[s+1] && !hazard;
        end else begin : g_rel_mid
            assign st_rel[s] = st_accept[s+1];
        end

        pl_stage #(
            .PW    (PW),
            .CNT_W (CNT_W)
        ) u_stage (
            .clk        (clk),
            .rst_n      (rst_n),
            .take       (take_s),
            .pay_in     (pin_s),
            .cnt_in     (cnt_s),
            .release_ok (st_rel[s]),
            .valid      (st_valid[s]),
            .pay        (st_pay[s]),
            .done       (st_done[s]),
            .leaving    (st_leave[s]),
            .accept     (st_accept[s])
        );
    end

    pl_scoreboard #(
        .TAG_W (TAG_W)
    ) u_board (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (st_leave[ST_D] && d_is_load),
        .set_tag (d_dst),
        .clr_en  (st_leave[ST_E] && e_is_load),
        .clr_tag (e_dst),
        .chk_a   (d_src_a),
        .chk_b   (d_src_b),
        .hazard  (hazard)
    );

    pl_cycle_ctr #(
        .W (CYC_W)
    ) u_cyc (
        .clk   (clk),
        .rst_n (rst_n),
        .count (cycle_count)
    );

    // Outputs: handshake, occupancy and retirement.
    assign in_ready     = st_accept[ST_F];
    assign stage_full   = st_valid;
    assign retire_valid = st_valid[ST_W];
    assign retire_seq   = st_pay[ST_W][SEQ_LO +: SEQ_W];

    // R1
    rst_clr_chk: assert property (@(posedge clk)
        !rst_n |=> (stage_full == 4'b0000 && !retire_valid));

    // R6
    bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid[ST_E] && !st_done[ST_E]) |=> !st_valid[ST_W]);

    // R5
    dec_to_exe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_leave[ST_D] |=> (st_valid[ST_E] && e_seq == $past(d_seq)));

    // R7
    dep_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_leave[ST_D] && st_valid[ST_E] && e_is_load)
            |-> (e_dst != d_src_a && e_dst != d_src_b));
endmodule

// File: tb/pipe_stall_ctrl_tb.sv
// pipe_stall_ctrl_tb
// Bench for the stall controller. For every instruction it computes the edge on
// which the instruction enters and leaves each stage. It compares occupancy,
// in_ready and the retire strobe against these edges in every cycle, and runs
// direct arithmetic checks on retire times.
module pipe_stall_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TAG_W = 3;
    localparam int SEQ_W = 8;
    localparam int CNT_W = 4;
    localparam int CYC_W = 32;
    localparam int MAXN = 16;
    localparam int WATCHDOG = 150000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [SEQ_W-1:0] in_seq = '0;
    logic [CNT_W-1:0] in_dec_cyc = '0;
    logic [CNT_W-1:0] in_exe_cyc = '0;
    logic             in_is_load = 1'b0;
    logic [TAG_W-1:0] in_dst = '0;
    logic [TAG_W-1:0] in_src_a = '0;
    logic [TAG_W-1:0] in_src_b = '0;
    logic [3:0]       stage_full;
    logic             retire_valid;
    logic [SEQ_W-1:0] retire_seq;
    logic [CYC_W-1:0] cycle_count;

    pipe_stall_ctrl #(
        .TAG_W (TAG_W), .SEQ_W (SEQ_W), .CNT_W (CNT_W), .CYC_W (CYC_W)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_ready (in_ready),
        .in_seq (in_seq), .in_dec_cyc (in_dec_cyc), .in_exe_cyc (in_exe_cyc),
        .in_is_load (in_is_load), .in_dst (in_dst), .in_src_a (in_src_a),
        .in_src_b (in_src_b), .stage_full (stage_full), .retire_valid (retire_valid),
        .retire_seq (retire_seq), .cycle_count (cycle_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int wd = 0;

    int q_n;
    int q_dec [MAXN];
    int q_exe [MAXN];
    int q_ld  [MAXN];
    int q_dst [MAXN];
    int q_sa  [MAXN];
    int q_sb  [MAXN];
    int m_t   [MAXN][4];
    int m_l   [MAXN][4];
    int ret_at [MAXN];
    int run_t0;

    always @(posedge clk) begin
        wd++;
        if (wd > WATCHDOG) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", wd, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    function automatic int nz(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic set_ins(input int j, input int d, input int e, input int ld,
                           input int dst, input int sa, input int sb);
        q_dec[j] = d; q_exe[j] = e; q_ld[j] = ld;
        q_dst[j] = dst; q_sa[j] = sa; q_sb[j] = sb;
    endtask

    // Stage entry/exit edges from the requirements (count values after the edge).
    task automatic model(input int t0);
        for (int j = 0; j < q_n; j++) begin
            m_t[j][0] = (j == 0) ? t0 : m_l[j-1][0];
            m_l[j][0] = m_t[j][0] + 1;
            if (j > 0) m_l[j][0] = mx(m_l[j][0], m_l[j-1][1]);
            m_t[j][1] = m_l[j][0];
            m_l[j][1] = m_t[j][1] + nz(q_dec[j]);
            if (j > 0) m_l[j][1] = mx(m_l[j][1], m_l[j-1][2]);
            for (int k = 0; k < j; k++)
                if (q_ld[k] != 0 && (q_dst[k] == q_sa[j] || q_dst[k] == q_sb[j]))
                    m_l[j][1] = mx(m_l[j][1], m_l[k][2] + 1);
            m_t[j][2] = m_l[j][1];
            m_l[j][2] = m_t[j][2] + nz(q_exe[j]);
            if (j > 0) m_l[j][2] = mx(m_l[j][2], m_l[j-1][3]);
            m_t[j][3] = m_l[j][2];
            m_l[j][3] = m_t[j][3] + 1;
        end
    endtask

    task automatic drive(input int j);
        in_seq     = SEQ_W'(j);
        in_dec_cyc = CNT_W'(q_dec[j]);
        in_exe_cyc = CNT_W'(q_exe[j]);
        in_is_load = (q_ld[j] != 0);
        in_dst     = TAG_W'(q_dst[j]);
        in_src_a   = TAG_W'(q_sa[j]);
        in_src_b   = TAG_W'(q_sb[j]);
    endtask

    task automatic run_seq(input string req);
        int fi, c, last, occ_bad, rdy_bad, ret_bad, nret, w_cycles;
        int bad_occ_act, bad_occ_exp;
        bit accepted;
        @(negedge clk);
        run_t0 = int'(cycle_count) + 1;
        model(run_t0);
        last = m_l[q_n-1][3];
        occ_bad = 0; rdy_bad = 0; ret_bad = 0; nret = 0; w_cycles = 0;
        bad_occ_act = 0; bad_occ_exp = 0;
        for (int j = 0; j < MAXN; j++) ret_at[j] = -1;
        fi = 0;
        drive(0);
        in_valid = 1'b1;
        forever begin
            logic [3:0] e_occ;
            bit e_rdy;
            int e_ret;
            c = int'(cycle_count);
            e_occ = 4'b0000;
            e_rdy = 1'b1;
            e_ret = -1;
            for (int j = 0; j < q_n; j++) begin
                for (int s = 0; s < 4; s++)
                    if (m_t[j][s] <= c && c < m_l[j][s]) e_occ[s] = 1'b1;
                if (m_t[j][0] <= c && c < m_l[j][0]) e_rdy = (m_l[j][0] == c + 1);
                if (m_t[j][3] == c) e_ret = j;
            end
            if (stage_full != e_occ) begin
                if (occ_bad == 0) begin
                    bad_occ_act = int'(stage_full);
                    bad_occ_exp = int'(e_occ);
                end
                occ_bad++;
            end
            if (in_ready != e_rdy) rdy_bad++;
            if (retire_valid) begin
                w_cycles++;
                if (int'(retire_seq) < MAXN) ret_at[int'(retire_seq)] = c;
            end
            if (e_ret >= 0) begin
                if (!retire_valid || int'(retire_seq) != e_ret) ret_bad++;
                else nret++;
            end else if (retire_valid) begin
                ret_bad++;
            end
            if (c >= last) break;
            accepted = in_valid && in_ready;
            @(negedge clk);
            if (accepted) begin
                fi++;
                if (fi < q_n) drive(fi);
                else in_valid = 1'b0;
            end
        end
        in_valid = 1'b0;
        check(occ_bad == 0, req, "stage occupancy mismatch (first)", bad_occ_act, bad_occ_exp);
        check(rdy_bad == 0, "R2", "in_ready mismatching cycles", rdy_bad, 0);
        check(ret_bad == 0 && nret == q_n, "R8", "retired in order", nret, q_n);
        check(w_cycles == q_n, "R6", "writeback occupied cycles", w_cycles, q_n);
    endtask

    initial begin
        int tot_a, tot_b, c1, exp_d;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(stage_full == 4'b0000, "R1", "stage_full in reset", stage_full, 0);
        check(!retire_valid, "R1", "retire_valid in reset", retire_valid, 0);
        check(cycle_count == '0, "R1", "cycle_count in reset", cycle_count, 0);
        check(in_ready, "R1", "in_ready in reset", in_ready, 1);
        rst_n = 1'b1;

        // R9: free-running counter
        @(negedge clk);
        c1 = int'(cycle_count);
        check(c1 == 1, "R9", "count after first edge", c1, 1);
        repeat (37) @(negedge clk);
        check(int'(cycle_count) == c1 + 37, "R9", "count after 37 edges", cycle_count, c1 + 37);

        // R3 / R4: lone instruction, every decode and execute count
        for (int d = 0; d < 16; d++) begin
            for (int e = 0; e < 16; e++) begin
                q_n = 1;
                set_ins(0, d, e, 0, 1, 2, 3);
                run_seq("R3");
                check(ret_at[0] - run_t0 == 1 + nz(d) + nz(e), "R4", "lone retire latency",
                      ret_at[0] - run_t0, 1 + nz(d) + nz(e));
            end
        end

        // R5: decode hold of a younger instruction overlaps the older execute hold
        for (int d2 = 0; d2 < 16; d2++) begin
            for (int e1 = 0; e1 < 16; e1++) begin
                q_n = 2;
                set_ins(0, 1, e1, 0, 1, 6, 7);
                set_ins(1, d2, 1, 0, 2, 6, 7);
                run_seq("R5");
                check(ret_at[0] == run_t0 + 2 + nz(e1), "R4", "older retire",
                      ret_at[0] - run_t0, 2 + nz(e1));
                check(ret_at[1] == run_t0 + 3 + mx(nz(d2), nz(e1)), "R5", "overlapped retire",
                      ret_at[1] - run_t0, 3 + mx(nz(d2), nz(e1)));
            end
        end

        // R7: load-use wait, with and without the load flag
        for (int ld = 0; ld < 2; ld++) begin
            for (int e = 0; e < 9; e++) begin
                for (int g = 0; g < 4; g++) begin
                    for (int w = 0; w < 2; w++) begin
                        q_n = g + 2;
                        set_ins(0, 1, e, ld, 2, 6, 7);
                        for (int f = 1; f <= g; f++) set_ins(f, 1, 1, 0, 5, 6, 7);
                        if (w == 0) set_ins(g + 1, 1, 1, 0, 4, 2, 7);
                        else        set_ins(g + 1, 1, 1, 0, 4, 6, 2);
                        run_seq("R7");
                        exp_d = (ld != 0 && g == 0) ? 2 : g + 1;
                        check(ret_at[g+1] - ret_at[0] == exp_d, "R7", "consumer retire gap",
                              ret_at[g+1] - ret_at[0], exp_d);
                    end
                end
            end
        end

        // R10: original order versus pops placed after the loads
        q_n = 10;
        set_ins(0, 4, 1, 0, 2, 6, 7);
        set_ins(1, 4, 1, 0, 3, 6, 7);
        set_ins(2, 1, 1, 0, 4, 6, 7);
        set_ins(3, 1, 1, 0, 4, 6, 7);
        set_ins(4, 1, 1, 0, 5, 6, 7);
        set_ins(5, 1, 1, 0, 5, 6, 7);
        set_ins(6, 1, 8, 1, 0, 4, 4);
        set_ins(7, 1, 8, 1, 1, 5, 5);
        set_ins(8, 1, 1, 0, 0, 0, 1);
        set_ins(9, 1, 1, 0, 7, 0, 4);
        run_seq("R10");
        tot_a = ret_at[9] - run_t0;
        check(tot_a == m_l[9][2] - run_t0, "R10", "original order total", tot_a, m_l[9][2] - run_t0);

        set_ins(0, 1, 1, 0, 4, 6, 7);
        set_ins(1, 1, 1, 0, 4, 6, 7);
        set_ins(2, 1, 1, 0, 5, 6, 7);
        set_ins(3, 1, 1, 0, 5, 6, 7);
        set_ins(4, 1, 8, 1, 0, 4, 4);
        set_ins(5, 4, 1, 0, 2, 6, 7);
        set_ins(6, 1, 8, 1, 1, 5, 5);
        set_ins(7, 4, 1, 0, 3, 6, 7);
        set_ins(8, 1, 1, 0, 0, 0, 1);
        set_ins(9, 1, 1, 0, 7, 0, 4);
        run_seq("R10");
        tot_b = ret_at[9] - run_t0;
        check(tot_b == m_l[9][2] - run_t0, "R10", "reordered total", tot_b, m_l[9][2] - run_t0);
        check(tot_b < tot_a, "R10", "reordered finishes sooner", tot_b, tot_a - 1);

        // R1: reset in the middle of a long hold empties everything
        q_n = 1;
        set_ins(0, 1, 15, 1, 3, 6, 7);
        drive(0);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(stage_full == 4'b0000, "R1", "stage_full after mid-run reset", stage_full, 0);
        check(cycle_count == '0, "R1", "cycle_count after mid-run reset", cycle_count, 0);
        rst_n = 1'b1;
        // R7: the scoreboard was cleared too, so a consumer of tag 3 does not wait
        q_n = 1;
        set_ins(0, 1, 1, 0, 4, 3, 3);
        run_seq("R7");
        check(ret_at[0] - run_t0 == 3, "R7", "no wait after reset", ret_at[0] - run_t0, 3);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule